// File: doc/BRIEF.md
# Echo-Capable Fetch Address Sequencer

This block produces the fetch address for a simple in-order core whose instruction set includes a replay ("echo") operation. The operation compresses code in the LZ77 style. It names a run of instructions already present earlier in the program, as a byte distance back from itself and a length. The sequencer jumps back by that distance and fetches exactly that many instructions. It then returns on its own to the instruction after the echo. No return instruction is needed.

Each cycle in which `adv_i` is high retires the instruction at `pc_o`. The decode information on that same cycle (echo or redirect) belongs to that instruction. Replay uses two dedicated registers, a saved return address and a remaining-count register. A single decrementer whose result is tested for zero with a NOR ends the replay. An echo therefore costs two control transfers: one backward jump and one return.

Top module: `echo_pc_seq`

## Requirements
- R1: After reset, `pc_o` equals the parameter RESET_PC and `echo_mode_o` is 0.
- R2: In a cycle with `adv_i` low, `pc_o` and `echo_mode_o` keep their values, whatever the other inputs carry.
- R3: An advance with no echo and no redirect, outside replay, moves `pc_o` to `pc_o + 4`.
- R4: An advance with `echo_i` high and `echo_cnt_i` nonzero, outside replay and without redirect, sets `pc_o` to the echo's own address minus `echo_ofs_i` (zero-extended) and sets `echo_mode_o` to 1.
- R5: Once replay has begun with count N, the next N advances fetch target, target+4, and so on. The Nth advance sets `pc_o` to the echo address + 4 and clears `echo_mode_o`.
- R6: An echo whose `echo_cnt_i` is 0 behaves as an ordinary instruction: `pc_o` advances by 4 and `echo_mode_o` stays 0.
- R7: An echo seen during replay starts no new replay. It counts as one replayed instruction and leaves the saved return address unchanged.
- R8: `redir_i` on an advance has priority over every other action. It loads `pc_o` from `redir_pc_i`, clears `echo_mode_o` and clears the remaining count, so a later advance steps by 4 with no return.
- R9: Address arithmetic wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Instruction at `pc_o` retires this cycle |
| echo_i | input | 1 | Retiring instruction is an echo |
| echo_ofs_i | input | OFS_W | Backward byte distance of the echo |
| echo_cnt_i | input | CNT_W | Number of instructions to replay |
| redir_i | input | 1 | Retiring instruction is a taken branch or jump |
| redir_pc_i | input | PC_W | Branch or jump target |
| pc_o | output | PC_W | Current fetch address |
| echo_mode_o | output | 1 | Fetch is inside a replayed run |

## Verification
Plain sequential runs are mixed with idle gaps and with echo operations of length 0, 1 and several. Comparing these shows whether the jump, the count and the return are each placed on the right advance. A nested echo inside a replay separates "ignored but counted" from both a restart and a pause of the countdown. Redirects inside and outside replay, followed by further advances, show whether the count really clears or a stale return would still fire. An echo placed near address zero checks that the backward jump wraps.

// File: rtl/echo_pc_seq_pkg.sv
package echo_pc_seq_pkg;
    localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/echo_pc_seq_cnt.sv
module echo_pc_seq_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q, dec_val;

    // single decrementer; NOR of its result flags the final replayed instruction
    always_comb begin
        dec_val = cnt_q - 1'b1;
        last_o  = ~|dec_val;
        cnt_d   = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (load_i)
            cnt_d = load_val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_d = dec_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R5: each replayed advance removes exactly one from the count
    a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && !clr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R8: a clear empties the count
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/echo_pc_seq_addr.sv
module echo_pc_seq_addr
    import echo_pc_seq_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  ret_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  back_o,
    output logic [PC_W-1:0]  resume_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    always_comb begin
        seq_o    = pc_i + STEP;
        back_o   = pc_i - PC_W'(ofs_i);
        resume_o = ret_i + STEP;
    end
endmodule

// File: rtl/echo_pc_seq.sv
module echo_pc_seq
    import echo_pc_seq_pkg::*;
#(
    parameter int unsigned    PC_W     = 32,
    parameter int unsigned    OFS_W    = 16,
    parameter int unsigned    CNT_W    = 8,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             echo_i,
    input  logic [OFS_W-1:0] echo_ofs_i,
    input  logic [CNT_W-1:0] echo_cnt_i,
    input  logic             redir_i,
    input  logic [PC_W-1:0]  redir_pc_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             echo_mode_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] ret;
        logic            mode;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [PC_W-1:0]  seq_pc, back_pc, resume_pc;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    logic             take_redir, start_echo, replay_step, replay_end;

    echo_pc_seq_addr #(.PC_W(PC_W), .OFS_W(OFS_W)) u_addr (
        .pc_i     (st_q.pc),
        .ret_i    (st_q.ret),
        .ofs_i    (echo_ofs_i),
        .seq_o    (seq_pc),
        .back_o   (back_pc),
        .resume_o (resume_pc)
    );

    always_comb begin
        take_redir  = adv_i && redir_i;
        start_echo  = adv_i && !redir_i && echo_i && !st_q.mode && (echo_cnt_i != '0);
        replay_step = adv_i && !redir_i && st_q.mode;
        replay_end  = replay_step && cnt_last;
    end

    echo_pc_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (take_redir),
        .load_i     (start_echo),
        .load_val_i (echo_cnt_i),
        .dec_i      (replay_step),
        .cnt_o      (cnt),
        .last_o     (cnt_last)
    );

    always_comb begin
        st_d = st_q;
        if (take_redir) begin
            st_d.pc   = redir_pc_i;
            st_d.mode = 1'b0;
        end else if (start_echo) begin
            st_d.ret  = st_q.pc;
            st_d.pc   = back_pc;
            st_d.mode = 1'b1;
        end else if (replay_end) begin
            st_d.pc   = resume_pc;
            st_d.mode = 1'b0;
        end else if (adv_i) begin
            st_d.pc   = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= RESET_PC;
            st_q.ret  <= '0;
            st_q.mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o        = st_q.pc;
    assign echo_mode_o = st_q.mode;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(pc_o) && $stable(echo_mode_o)));

    a_r4_jump_back: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !redir_i && echo_i && !echo_mode_o && echo_cnt_i != '0)
        |=> (echo_mode_o && pc_o == $past(pc_o) - PC_W'($past(echo_ofs_i))));

    a_r5_mode_count: assert property (@(posedge clk) disable iff (!rst_n)
        echo_mode_o |-> cnt != '0);

    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !redir_i && echo_i && !echo_mode_o && echo_cnt_i == '0)
        |=> (!echo_mode_o && pc_o == $past(pc_o) + PC_W'(INSN_BYTES)));

    a_r7_nested_keeps_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_mode_o && echo_i && adv_i) |=> $stable(st_q.ret));

    a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && redir_i) |=> (!echo_mode_o && pc_o == $past(redir_pc_i)));
endmodule

// File: tb/echo_pc_seq_bench.sv
module echo_pc_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32, OFS_W = 16, CNT_W = 8;
    localparam logic [PC_W-1:0] RST_PC = 32'h0000_0100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic adv = 0, echo = 0, redir = 0;
    logic [OFS_W-1:0] ofs = '0;
    logic [CNT_W-1:0] n = '0;
    logic [PC_W-1:0] rpc = '0;
    logic [PC_W-1:0] pc;
    logic mode;

    int tests = 0, fails = 0;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic            mode;
        string           tag;
    } exp_t;
    exp_t q[$];

    logic [PC_W-1:0]  m_pc = RST_PC, m_ret = '0;
    logic             m_mode = 0;
    logic [CNT_W-1:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    echo_pc_seq #(.PC_W(PC_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .RESET_PC(RST_PC)) u_echo_pc_seq (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .echo_i(echo), .echo_ofs_i(ofs),
        .echo_cnt_i(n), .redir_i(redir), .redir_pc_i(rpc), .pc_o(pc), .echo_mode_o(mode)
    );

    task automatic check(input string tag, input logic [PC_W-1:0] epc, input logic emode);
        tests++;
        if (pc !== epc || mode !== emode) begin
            fails++;
            $display("FAIL %s: pc=%h mode=%b expected pc=%h mode=%b", tag, pc, mode, epc, emode);
        end
    endtask

    // driver: apply one cycle of inputs, advance the model, queue the expectation
    task automatic step(input logic a, input logic e, input logic [OFS_W-1:0] o,
                        input logic [CNT_W-1:0] c, input logic r,
                        input logic [PC_W-1:0] t, input string tag);
        exp_t x;
        @(negedge clk);
        adv = a; echo = e; ofs = o; n = c; redir = r; rpc = t;
        if (a) begin
            if (r) begin
                m_pc = t; m_mode = 0; m_cnt = '0;
            end else if (e && !m_mode && c != 0) begin
                m_ret = m_pc; m_pc = m_pc - PC_W'(o); m_mode = 1; m_cnt = c;
            end else if (m_mode) begin
                m_cnt = m_cnt - 1'b1;
                if (m_cnt == 0) begin
                    m_pc = m_ret + 4; m_mode = 0;
                end else m_pc = m_pc + 4;
            end else m_pc = m_pc + 4;
        end
        x.pc = m_pc; x.mode = m_mode; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic seq(input string tag);
        step(1, 0, '0, '0, 0, '0, tag);
    endtask

    // monitor: just after each edge, compare against the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                exp_t x;
                x = q.pop_front();
                check(x.tag, x.pc, x.mode);
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                tests++; fails++;
                $display("FAIL watchdog: cycles=%0d expected <= 20000", cyc);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pc", RST_PC, 1'b0);
        rst_n = 1'b1;
        seq("R3 seq");
        seq("R3 seq");
        seq("R3 seq");
        // R2: idle cycles with noisy echo/redirect
        step(0, 1, 16'd8, 8'd3, 0, '0, "R2 idle echo");
        step(0, 0, '0, '0, 1, 32'h900, "R2 idle redirect");
        // R4/R5: echo at 0x10C, back 8, length 3
        step(1, 1, 16'd8, 8'd3, 0, '0, "R4 jump back");
        seq("R5 replay 1");
        step(0, 0, '0, '0, 0, '0, "R2 idle in replay");
        seq("R5 replay 2");
        seq("R5 replay 3 return");
        seq("R3 after return");
        // R6: zero-length echo
        step(1, 1, 16'd4, 8'd0, 0, '0, "R6 zero length");
        // length 1
        step(1, 1, 16'd12, 8'd1, 0, '0, "R4 len1 jump");
        seq("R5 len1 return");
        // R7: nested echo during replay
        step(1, 1, 16'd16, 8'd4, 0, '0, "R4 jump");
        seq("R5 replay");
        step(1, 1, 16'd40, 8'd9, 0, '0, "R7 nested ignored");
        seq("R7 replay continues");
        seq("R7 return to first echo");
        // R8: redirect inside replay
        step(1, 1, 16'd20, 8'd5, 0, '0, "R4 jump");
        seq("R5 replay");
        step(1, 1, 16'd4, 8'd2, 1, 32'h400, "R8 redirect in replay");
        seq("R8 no stale return");
        seq("R8 no stale return");
        seq("R8 no stale return");
        step(1, 0, '0, '0, 1, 32'h8, "R8 redirect plain");
        // R9: backward jump wraps below zero
        step(1, 1, 16'h20, 8'd2, 0, '0, "R9 wrap jump");
        seq("R9 wrap replay");
        seq("R9 wrap return");
        @(negedge clk);
        adv = 0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule